// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor core and a data memory that is 32 bits wide, byte addressed and little-endian. For every access the core presents a base register value, a signed 16-bit displacement, an access size (byte, halfword or word), a direction and, for loads, a signedness flag. The unit adds the displacement to the base, checks that the result suits the access size, and drives the memory with a word address, per-lane byte enables and, for stores, a write word with the source data copied into every lane it may land in.

Memory always returns a whole word one clock after a read is issued. The unit keeps the lane, size and signedness of each accepted load in a two-state machine. In that return cycle it picks the addressed bytes out of the returned word and extends them to 32 bits with sign or zeros. The states are `ST_IDLE` (no load data due) and `ST_LOAD_RETURN` (load data is on `mem_rdata` this cycle). Transitions: `ST_IDLE -> ST_LOAD_RETURN` and `ST_LOAD_RETURN -> ST_LOAD_RETURN` when a load is accepted. `ST_LOAD_RETURN -> ST_IDLE` and `ST_IDLE -> ST_IDLE` in any other cycle. Reset returns the machine to `ST_IDLE` at once.

Top module: `lsu_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. `mem_addr[31:2]` carries bits 31:2 of that sum whenever `req_valid` is high.
- R2: `mem_addr[1:0]` is always 00. Bits 1:0 of the effective address are the byte lane, with lane 0 holding data bits 7:0.
- R3: For a byte access (`req_size` = 00), `mem_be` is 0001 shifted left by the lane. Any lane is legal.
- R4: For a halfword access (`req_size` = 01) at lane 0 or 2, `mem_be` is 0011 or 1100. For a word access (`req_size` = 10) at lane 0, `mem_be` is 1111.
- R5: A halfword at an odd lane, a word at a nonzero lane, or the reserved size code 11 raises `align_fault`. It forces `mem_be` to 0000 and holds `mem_en` and `mem_we` low, and no load data is returned for it.
- R6: `mem_wdata` copies `req_wdata[7:0]` into all four lanes for a byte access and `req_wdata[15:0]` into both halves for a halfword. It passes `req_wdata` unchanged for a word or the reserved code.
- R7: `mem_en` is high for a valid request that does not fault. `mem_we` is high only when `mem_en` is high and `req_store` is 1, so a load drives enables with `mem_we` low.
- R8: `load_valid` is high in exactly the cycle after an accepted load and in no other cycle. `load_data` is 0 whenever `load_valid` is low.
- R9: A signed byte load (`req_unsigned` = 0) returns the addressed byte of `mem_rdata`, sign-extended.
- R10: An unsigned byte load (`req_unsigned` = 1) returns the addressed byte, zero-extended.
- R11: A halfword load returns `mem_rdata[15:0]` for lane 0 and `mem_rdata[31:16]` for lane 2. The value is sign-extended or zero-extended according to `req_unsigned`.
- R12: A word load returns `mem_rdata` unchanged.
- R13: While `rst_n` is low, `load_valid` is 0 and `load_data` is 0. This takes effect without waiting for a clock edge.
- R14: With `req_valid` low, `mem_be` is 0000 and `align_fault`, `mem_en` and `mem_we` are 0, whatever the other request inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Load extension: 1 = zero, 0 = sign |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Word address to memory, low two bits zero |
| mem_en | output | 1 | Access issued to memory |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word returned one cycle after a read |
| align_fault | output | 1 | Misaligned or reserved-size request |
| load_valid | output | 1 | Extended load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The bench targets the lane arithmetic where a negative displacement carries into the lane bits or wraps the address through zero. A wrong adder or a missing sign extension would put the enables on the wrong lane and shift the word address by one. It loads bytes and halfwords whose top bit is set, in lanes 1, 2 and 3, so a design that extends from the wrong bit or selects the wrong half gives a different upper word. It issues misaligned halfwords and words and the reserved size code to catch enables or write strobes that leak past a fault. It runs back-to-back loads with different lanes and signedness to expose a design that formats the second return with the first load's lane.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE        = 1'b0,
        ST_LOAD_RETURN = 1'b1
    } lsu_state_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                req_valid,
    input  acc_size_e           size,
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFF_W-1:0]    offset,
    output logic [ADDR_W-1:0]   word_addr,
    output logic [LANE_W-1:0]   lane,
    output logic                fault,
    output logic [BYTES-1:0]    byte_en
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff_addr;
    logic              misaligned;
    logic [BYTES-1:0]  pattern;

    // base + sign-extended displacement, wrapping modulo 2^ADDR_W
    assign eff_addr  = base + {{EXT_W{offset[OFF_W-1]}}, offset};
    assign lane      = eff_addr[LANE_W-1:0];
    assign word_addr = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    always_comb begin
        misaligned = 1'b0;
        pattern    = '0;
        unique case (size)
            SZ_BYTE: begin
                pattern = {{(BYTES-1){1'b0}}, 1'b1} << lane;
            end
            SZ_HALF: begin
                misaligned = lane[0];
                pattern    = {{(BYTES-2){1'b0}}, 2'b11} << {lane[LANE_W-1:1], 1'b0};
            end
            SZ_WORD: begin
                misaligned = |lane;
                pattern    = '1;
            end
            SZ_RSVD: begin
                misaligned = 1'b1;
            end
        endcase
    end

    assign fault   = req_valid & misaligned;
    assign byte_en = (req_valid && !misaligned) ? pattern : '0;
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
(
    input  acc_size_e          size,
    input  logic [DATA_W-1:0]  src,
    output logic [DATA_W-1:0]  wdata
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        localparam int HALF_IDX = g % 2;
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[g*8 +: 8] = src[7:0];
                SZ_HALF: wdata[g*8 +: 8] = src[HALF_IDX*8 +: 8];
                default: wdata[g*8 +: 8] = src[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format
    import lsu_pkg::*;
(
    input  logic [DATA_W-1:0]  rdata,
    input  logic [LANE_W-1:0]  lane,
    input  acc_size_e          size,
    input  logic               zero_ext,
    output logic [DATA_W-1:0]  result
);
    logic [DATA_W-1:0] aligned;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;

    // move the addressed lane down to bit 0
    assign aligned = rdata >> {lane, 3'b000};
    assign byte_v  = aligned[7:0];
    assign half_v  = aligned[15:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){byte_v[7] & ~zero_ext}}, byte_v};
            SZ_HALF: result = {{(DATA_W-16){half_v[15] & ~zero_ext}}, half_v};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic               req_unsigned,
    input  logic [ADDR_W-1:0]  req_base,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_en,
    output logic               mem_we,
    output logic [BYTES-1:0]   mem_be,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               align_fault,
    output logic               load_valid,
    output logic [DATA_W-1:0]  load_data
);
    acc_size_e          size_in;
    logic [LANE_W-1:0]  lane;
    logic               load_accept;
    lsu_state_e         state_q, state_d;
    logic [LANE_W-1:0]  lane_q;
    acc_size_e          size_q;
    logic               zext_q;
    logic [DATA_W-1:0]  fmt_data;

    assign size_in = acc_size_e'(req_size);

    lsu_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_addr_gen (
        .req_valid (req_valid),
        .size      (size_in),
        .base      (req_base),
        .offset    (req_offset),
        .word_addr (mem_addr),
        .lane      (lane),
        .fault     (align_fault),
        .byte_en   (mem_be)
    );

    assign mem_en      = req_valid & ~align_fault;
    assign mem_we      = mem_en & req_store;
    assign load_accept = mem_en & ~req_store;

    lsu_store_steer u_store_steer (
        .size  (size_in),
        .src   (req_wdata),
        .wdata (mem_wdata)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        state_d = load_accept ? ST_LOAD_RETURN : ST_IDLE;
            ST_LOAD_RETURN: state_d = load_accept ? ST_LOAD_RETURN : ST_IDLE;
        endcase
    end

    // state register with the context of the load in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            size_q  <= SZ_BYTE;
            zext_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_accept) begin
                lane_q <= lane;
                size_q <= size_in;
                zext_q <= req_unsigned;
            end
        end
    end

    lsu_load_format u_load_format (
        .rdata    (mem_rdata),
        .lane     (lane_q),
        .size     (size_q),
        .zero_ext (zext_q),
        .result   (fmt_data)
    );

    // outputs
    always_comb begin
        load_valid = 1'b0;
        load_data  = '0;
        unique case (state_q)
            ST_IDLE: begin
                load_valid = 1'b0;
                load_data  = '0;
            end
            ST_LOAD_RETURN: begin
                load_valid = 1'b1;
                load_data  = fmt_data;
            end
        endcase
    end

    // ---------------- assertions ----------------
    assert_fault_blocks_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_be == '0 && !mem_en && !mem_we));

    assert_idle_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_be == '0 && !align_fault && !mem_we));

    assert_half_word_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && req_size != 2'd0) |-> ($countones(mem_be) == 2 || $countones(mem_be) == 4));

    assert_byte_enable_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && req_size == 2'd0) |-> $countones(mem_be) == 1);

    assert_we_only_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (req_store && mem_be != '0));

    assert_load_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !req_store) |=> load_valid);

    assert_no_stray_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(mem_en && !req_store));

    assert_signed_byte_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && size_q == SZ_BYTE && !zext_q) |-> load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}});

    assert_unsigned_byte_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && size_q == SZ_BYTE && zext_q) |-> load_data[DATA_W-1:8] == '0);
endmodule

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        st;
        logic [1:0]  sz;
        logic        un;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] sdata;
        logic [31:0] rdata;
        logic        flt;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] ldata;
        logic        ld;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 32'h00002000, 16'h0045, 32'h12345678, 32'h134982FE, 1'b0, 4'b0010, 32'h00002044, 32'h78787878, 32'hFFFFFF82, 1'b1},
        '{1'b0, 2'd0, 1'b1, 32'h0000204C, 16'hFFF9, 32'h00000000, 32'h134982FE, 1'b0, 4'b0010, 32'h00002044, 32'h00000000, 32'h00000082, 1'b1},
        '{1'b0, 2'd1, 1'b0, 32'h0000204C, 16'hFFFA, 32'hAABBCCDD, 32'hF8BE97CD, 1'b0, 4'b1100, 32'h00002044, 32'hCCDDCCDD, 32'hFFFFF8BE, 1'b1},
        '{1'b0, 2'd1, 1'b1, 32'h0000204C, 16'hFFFC, 32'h00000000, 32'h5A12C5B7, 1'b0, 4'b0011, 32'h00002048, 32'h00000000, 32'h0000C5B7, 1'b1},
        '{1'b0, 2'd2, 1'b0, 32'h00002000, 16'h0040, 32'h00000000, 32'hF8BE97CD, 1'b0, 4'b1111, 32'h00002040, 32'h00000000, 32'hF8BE97CD, 1'b1},
        '{1'b1, 2'd0, 1'b0, 32'h0000204C, 16'hFFFB, 32'h123489AB, 32'h00000000, 1'b0, 4'b1000, 32'h00002044, 32'hABABABAB, 32'h00000000, 1'b0},
        '{1'b1, 2'd1, 1'b0, 32'h0000204C, 16'hFFFE, 32'h123489AB, 32'h00000000, 1'b0, 4'b1100, 32'h00002048, 32'h89AB89AB, 32'h00000000, 1'b0},
        '{1'b1, 2'd2, 1'b0, 32'h00002000, 16'h0040, 32'h123489AB, 32'h00000000, 1'b0, 4'b1111, 32'h00002040, 32'h123489AB, 32'h00000000, 1'b0},
        '{1'b0, 2'd1, 1'b0, 32'h0000FFE5, 16'h0000, 32'h0000BEEF, 32'hDEADBEEF, 1'b1, 4'b0000, 32'h0000FFE4, 32'hBEEFBEEF, 32'h00000000, 1'b0},
        '{1'b1, 2'd2, 1'b0, 32'h0000A18E, 16'h0000, 32'h11223344, 32'h00000000, 1'b1, 4'b0000, 32'h0000A18C, 32'h11223344, 32'h00000000, 1'b0},
        '{1'b0, 2'd2, 1'b0, 32'h0000A180, 16'h000E, 32'h55667788, 32'h12345678, 1'b1, 4'b0000, 32'h0000A18C, 32'h55667788, 32'h00000000, 1'b0},
        '{1'b1, 2'd0, 1'b0, 32'hFFFFFFFF, 16'h0001, 32'h000000C3, 32'h00000000, 1'b0, 4'b0001, 32'h00000000, 32'hC3C3C3C3, 32'h00000000, 1'b0},
        '{1'b0, 2'd0, 1'b0, 32'h00000010, 16'hFFF3, 32'h00000000, 32'h7F001122, 1'b0, 4'b1000, 32'h00000000, 32'h00000000, 32'h0000007F, 1'b1},
        '{1'b0, 2'd3, 1'b0, 32'h00000100, 16'h0000, 32'h01020304, 32'h00000000, 1'b1, 4'b0000, 32'h00000100, 32'h01020304, 32'h00000000, 1'b0},
        '{1'b0, 2'd1, 1'b1, 32'h00000100, 16'h0002, 32'h00000000, 32'h9ABC1234, 1'b0, 4'b1100, 32'h00000100, 32'h00000000, 32'h00009ABC, 1'b1},
        '{1'b0, 2'd0, 1'b1, 32'h00000003, 16'h0000, 32'h00000000, 32'h80FFFFFF, 1'b0, 4'b1000, 32'h00000000, 32'h00000000, 32'h00000080, 1'b1},
        '{1'b0, 2'd0, 1'b0, 32'h00000000, 16'h0000, 32'h00000000, 32'h00000080, 1'b0, 4'b0001, 32'h00000000, 32'h00000000, 32'hFFFFFF80, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr;
    logic        mem_en, mem_we, align_fault, load_valid;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_store    (req_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_base     (req_base),
        .req_offset   (req_offset),
        .req_wdata    (req_wdata),
        .mem_addr     (mem_addr),
        .mem_en       (mem_en),
        .mem_we       (mem_we),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .align_fault  (align_fault),
        .load_valid   (load_valid),
        .load_data    (load_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string load_req(input logic [1:0] sz, input logic un);
        if (sz == 2'd0) return un ? "R10 unsigned byte load" : "R9 signed byte load";
        if (sz == 2'd1) return "R11 halfword load";
        return "R12 word load";
    endfunction

    task automatic drive(input logic st, input logic [1:0] sz, input logic un,
                         input logic [31:0] b, input logic [15:0] o, input logic [31:0] sd);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = un;
        req_base = b; req_offset = o; req_wdata = sd;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // reset state (R13)
        repeat (2) @(negedge clk);
        #1;
        chk("R13 load_valid in reset", {31'b0, load_valid}, 32'd0);
        chk("R13 load_data in reset", load_data, 32'd0);
        chk("R14 mem_be idle", {28'b0, mem_be}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].st, VECS[i].sz, VECS[i].un, VECS[i].base, VECS[i].off, VECS[i].sdata);
            #1;
            chk("R1 R2 mem_addr", mem_addr, VECS[i].addr);
            chk(VECS[i].sz == 2'd0 ? "R3 byte enables" : "R4 R5 byte enables", {28'b0, mem_be}, {28'b0, VECS[i].be});
            chk("R5 align_fault", {31'b0, align_fault}, {31'b0, VECS[i].flt});
            chk("R7 mem_en", {31'b0, mem_en}, {31'b0, ~VECS[i].flt});
            chk("R7 mem_we", {31'b0, mem_we}, {31'b0, VECS[i].st & ~VECS[i].flt});
            chk("R6 mem_wdata", mem_wdata, VECS[i].wdata);
            @(negedge clk);
            req_valid = 1'b0;
            mem_rdata = VECS[i].rdata;
            #1;
            chk("R8 load_valid", {31'b0, load_valid}, {31'b0, VECS[i].ld});
            chk(VECS[i].ld ? load_req(VECS[i].sz, VECS[i].un) : "R8 load_data idle",
                load_data, VECS[i].ldata);
        end

        // R14: invalid request with misaligned store fields
        @(negedge clk);
        req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2;
        req_base = 32'h00000003; req_offset = 16'h0000;
        #1;
        chk("R14 mem_be without valid", {28'b0, mem_be}, 32'd0);
        chk("R14 align_fault without valid", {31'b0, align_fault}, 32'd0);
        chk("R14 mem_we without valid", {31'b0, mem_we}, 32'd0);
        @(negedge clk);
        #1;
        chk("R8 no return after idle", {31'b0, load_valid}, 32'd0);

        // back-to-back loads with different lanes and signedness
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b1, 32'h00002045, 16'h0000, 32'h0);
        @(negedge clk);
        drive(1'b0, 2'd1, 1'b0, 32'h00002046, 16'h0000, 32'h0);
        mem_rdata = 32'h0000AB00;
        #1;
        chk("R10 first of back-to-back", load_data, 32'h000000AB);
        chk("R8 first of back-to-back valid", {31'b0, load_valid}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = 32'h80010000;
        #1;
        chk("R11 second of back-to-back", load_data, 32'hFFFF8001);
        chk("R8 second of back-to-back valid", {31'b0, load_valid}, 32'd1);
        @(negedge clk);
        #1;
        chk("R8 return ends", {31'b0, load_valid}, 32'd0);

        // reset while a load is pending
        @(negedge clk);
        drive(1'b0, 2'd2, 1'b0, 32'h00000040, 16'h0000, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = 32'hCAFEF00D;
        #1;
        chk("R12 word before reset", load_data, 32'hCAFEF00D);
        rst_n = 1'b0;
        #1;
        chk("R13 reset drops load_valid", {31'b0, load_valid}, 32'd0);
        chk("R13 reset clears load_data", load_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule